// File: doc/BRIEF.md
# Position-Ordered Register Wakeup Matrix

This block is the wakeup half of an out-of-order scheduler that works without register renaming. Instructions occupy rows of a circular queue in program order. Each row records, as one bit per logical register, which registers it reads and which it writes. Readiness for a register flows down that register's column from the oldest row. Any row that writes the register and has not yet been granted cuts the flow for every younger row. A row asks for issue once none of the registers it reads is cut above it.

An external select stage returns a grant vector. A granted row stops asking, and it stops blocking its destination columns, so younger dependents wake. The head row leaves the queue on commit, but only once it has been granted. A flush names one occupied slot and discards every row younger than that slot. Allocation then resumes right after the named slot.

The request vector is combinational from the row state. It therefore reflects every allocation, grant, commit and flush immediately after the clock edge that applies it.

Top module: `wkq_wakeup_array`

## Requirements
- R1: While reset is asserted and right after it, the queue is empty and `req_o` is all zero; the first allocation after reset lands in slot 0.
- R2: An allocated row whose source mask is zero, or whose sources have no pending older writer, drives its bit of `req_o` (bit index = slot number) high right after the allocating edge.
- R3: A row does not request while any older, valid, not-yet-granted row writes a register it reads; the oldest (head) row that is valid and ungranted always requests.
- R4: A grant on a requesting row clears that row's request and removes its blocking, so younger readers of its destination registers request right after the granting edge.
- R5: Blocking is per column and per position: a writer blocks only readers of the registers it writes, and only rows younger than itself.
- R6: With several older ungranted writers of one register, a reader stays blocked until all of them are granted.
- R7: A grant bit on a row that is not requesting has no effect.
- R8: An allocation while all DEPTH slots are full is ignored; the queue contents and tail are unchanged.
- R9: `commit_i` retires the head row only when it has been granted; otherwise, or on an empty queue, it is ignored.
- R10: A flush at occupied slot P removes every row younger than P and keeps P and older rows; the next allocation goes to slot P+1; an allocation in the flush cycle is ignored.
- R11: Slots are used as a circular buffer of DEPTH entries (slot after DEPTH-1 is 0); age ordering, and hence blocking, follows queue position across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Allocate one row at the tail |
| alloc_src_i | input | NREG | Registers read by the new row, bit per logical register |
| alloc_dst_i | input | NREG | Registers written by the new row |
| grant_i | input | DEPTH | Grant vector from select, bit per slot |
| commit_i | input | 1 | Retire the head row if granted |
| flush_i | input | 1 | Discard rows younger than flush_pos_i |
| flush_pos_i | input | $clog2(DEPTH) | Slot of the offending entry, kept |
| req_o | output | DEPTH | Issue request per slot |

## Verification
Every input is applied at one rising edge. Its effect on `req_o` is due right after that same edge, because requests are decoded from registered row state with no further stage. The bench therefore drives inputs on the falling edge and compares `req_o` at the next falling edge, one half-period after the edge that consumed the stimulus. Ignored stimuli (full allocation, grant without request, commit of an ungranted head, allocation during flush) are followed by a step whose expected requests would differ had the stimulus taken effect.

// File: rtl/wkq_pkg.sv
package wkq_pkg;
  // action applied to the tail pointer in one cycle
  typedef enum logic [1:0] {
    TAIL_HOLD   = 2'd0,
    TAIL_STEP   = 2'd1,
    TAIL_REWIND = 2'd2
  } tail_op_e;
endpackage

// File: rtl/wkq_ptrs.sv
module wkq_ptrs
  import wkq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_do_i,
  input  logic          commit_do_i,
  input  logic          flush_do_i,
  input  logic [PW-1:0] flush_pos_i,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] tail_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] head_q, head_n, tail_q, tail_n;
  logic [CW-1:0] count_q, count_n;
  logic [PW-1:0] flush_age;
  tail_op_e      tail_op;
  logic          ptr_en;

  assign flush_age = flush_pos_i - head_q;

  always_comb begin
    if (flush_do_i)      tail_op = TAIL_REWIND;
    else if (alloc_do_i) tail_op = TAIL_STEP;
    else                 tail_op = TAIL_HOLD;
  end

  always_comb begin
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    case (tail_op)
      TAIL_REWIND: begin
        tail_n  = flush_pos_i + 1'b1;
        count_n = CW'(flush_age) + 1'b1;
      end
      TAIL_STEP: begin
        tail_n  = tail_q + 1'b1;
        count_n = count_q + 1'b1;
      end
      default: ;
    endcase
    if (commit_do_i && !flush_do_i) begin
      head_n  = head_q + 1'b1;
      count_n = count_n - 1'b1;
    end
  end

  assign ptr_en = alloc_do_i | commit_do_i | flush_do_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  // R10
  flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_do_i |=> (tail_q == $past(flush_pos_i) + 1'b1));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> (count_q != '0 || $past(flush_do_i) || $past(commit_do_i)));
endmodule

// File: rtl/wkq_row.sv
module wkq_row #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NREG-1:0] wr_src_i,
  input  logic [NREG-1:0] wr_dst_i,
  input  logic            grant_i,
  input  logic            clear_i,
  input  logic [NREG-1:0] block_i,
  output logic            valid_o,
  output logic            granted_o,
  output logic [NREG-1:0] pend_dst_o,
  output logic            req_o
);
  logic            vld_q, vld_n;
  logic            gnt_q, gnt_n;
  logic [NREG-1:0] src_q, src_n, dst_q, dst_n;
  logic            row_en;

  assign req_o = vld_q && !gnt_q && ((src_q & block_i) == '0);

  always_comb begin
    vld_n = vld_q;
    gnt_n = gnt_q;
    src_n = src_q;
    dst_n = dst_q;
    if (clear_i) begin
      vld_n = 1'b0;
      gnt_n = 1'b0;
    end else if (wr_i) begin
      vld_n = 1'b1;
      gnt_n = 1'b0;
      src_n = wr_src_i;
      dst_n = wr_dst_i;
    end else if (grant_i && req_o) begin
      gnt_n = 1'b1;
    end
  end

  assign row_en = clear_i | wr_i | (grant_i & req_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      gnt_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
    end else if (row_en) begin
      vld_q <= vld_n;
      gnt_q <= gnt_n;
      src_q <= src_n;
      dst_q <= dst_n;
    end
  end

  assign valid_o    = vld_q;
  assign granted_o  = gnt_q;
  assign pend_dst_o = (vld_q && !gnt_q) ? dst_q : '0;

  // R7
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(req_o));
  // R4
  granted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && req_o && !clear_i && !wr_i) |=> !req_o);
endmodule

// File: rtl/wkq_ready_scan.sv
module wkq_ready_scan #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [PW-1:0]   head_i,
  input  logic [NREG-1:0] pend_i  [DEPTH],
  output logic [NREG-1:0] block_o [DEPTH]
);
  // walk the slots oldest first; each slot sees the OR of pending
  // writers above it, per column
  always_comb begin
    logic [NREG-1:0] acc;
    logic [PW-1:0]   idx;
    acc = '0;
    idx = '0;
    for (int s = 0; s < DEPTH; s++) block_o[s] = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx          = head_i + PW'(k);
      block_o[idx] = acc;
      acc          = acc | pend_i[idx];
    end
  end
endmodule

// File: rtl/wkq_wakeup_array.sv
module wkq_wakeup_array #(
  parameter int DEPTH = 8,
  parameter int NREG  = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid_i,
  input  logic [NREG-1:0]  alloc_src_i,
  input  logic [NREG-1:0]  alloc_dst_i,
  input  logic [DEPTH-1:0] grant_i,
  input  logic             commit_i,
  input  logic             flush_i,
  input  logic [PW-1:0]    flush_pos_i,
  output logic [DEPTH-1:0] req_o
);
  logic [PW-1:0]    head, tail, flush_age;
  logic             full, empty;
  logic             alloc_do, commit_do, flush_do;
  logic [DEPTH-1:0] row_valid, row_gnt, row_wr, row_clr;
  logic [NREG-1:0]  pend  [DEPTH];
  logic [NREG-1:0]  block [DEPTH];

  assign flush_do  = flush_i && !empty;
  assign alloc_do  = alloc_valid_i && !full && !flush_i;
  assign commit_do = commit_i && !empty && !flush_i && row_gnt[head];
  assign flush_age = flush_pos_i - head;

  wkq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_do_i  (alloc_do),
    .commit_do_i (commit_do),
    .flush_do_i  (flush_do),
    .flush_pos_i (flush_pos_i),
    .head_o      (head),
    .tail_o      (tail),
    .full_o      (full),
    .empty_o     (empty)
  );

  wkq_ready_scan #(.DEPTH(DEPTH), .NREG(NREG)) u_scan (
    .head_i  (head),
    .pend_i  (pend),
    .block_o (block)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_row
    logic [PW-1:0] age;
    assign age        = PW'(s) - head;
    assign row_wr[s]  = alloc_do && (tail == PW'(s));
    assign row_clr[s] = (commit_do && (head == PW'(s))) ||
                        (flush_do && row_valid[s] && (age > flush_age));

    wkq_row #(.NREG(NREG)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (row_wr[s]),
      .wr_src_i   (alloc_src_i),
      .wr_dst_i   (alloc_dst_i),
      .grant_i    (grant_i[s]),
      .clear_i    (row_clr[s]),
      .block_i    (block[s]),
      .valid_o    (row_valid[s]),
      .granted_o  (row_gnt[s]),
      .pend_dst_o (pend[s]),
      .req_o      (req_o[s])
    );
  end

  // R3
  head_never_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid[head] && !row_gnt[head]) |-> req_o[head]);
  // R8
  full_alloc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid_i && full && !flush_i) |=> $stable(tail));
  // R9
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !flush_i && !row_gnt[head]) |=> $stable(head));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (req_o == '0));
endmodule

// File: tb/tb_wkq_wakeup_array.sv
module tb_wkq_wakeup_array;
  localparam int DEPTH = 8;
  localparam int NREG  = 8;
  localparam int NV    = 30;

  typedef struct packed {
    logic       alloc;
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] gnt;
    logic       commit;
    logic       flush;
    logic [2:0] fpos;
    logic [7:0] exp;
    logic [3:0] rid;
  } vec_t;

  // req bit index = slot; slot k = k-th allocation after reset (mod 8)
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 8'h01, 4'd2},  // R2
    '{1'b1, 8'h02, 8'h04, 8'h00, 1'b0, 1'b0, 3'd0, 8'h01, 4'd3},  // R3
    '{1'b1, 8'h04, 8'h08, 8'h00, 1'b0, 1'b0, 3'd0, 8'h01, 4'd3},  // R3
    '{1'b1, 8'h20, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h09, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0, 8'h0A, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h00, 8'h04, 1'b0, 1'b0, 3'd0, 8'h0A, 4'd7},  // R7
    '{1'b1, 8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 8'h1A, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h00, 8'h02, 1'b0, 1'b0, 3'd0, 8'h1C, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h1C, 4'd9},  // R9
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h1C, 4'd9},  // R9
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h1C, 4'd9},  // R9
    '{1'b1, 8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 8'h3C, 4'd6},  // R6
    '{1'b1, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h3C, 4'd6},  // R6
    '{1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 1'b0, 3'd0, 8'h2C, 4'd6},  // R6
    '{1'b0, 8'h00, 8'h00, 8'h20, 1'b0, 1'b0, 3'd0, 8'h4C, 4'd6},  // R6
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd3, 8'h0C, 4'd10}, // R10
    '{1'b1, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h1C, 4'd10}, // R10
    '{1'b0, 8'h00, 8'h00, 8'h04, 1'b0, 1'b0, 3'd0, 8'h18, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h18, 4'd9},  // R9
    '{1'b1, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, 3'd0, 8'h38, 4'd2},  // R2
    '{1'b1, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h38, 4'd3},  // R3
    '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'hB8, 4'd2},  // R2
    '{1'b1, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'hB8, 4'd11}, // R11
    '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'hBA, 4'd11}, // R11
    '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'hBE, 4'd11}, // R11
    '{1'b1, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, 3'd0, 8'hBE, 4'd8},  // R8
    '{1'b0, 8'h00, 8'h00, 8'h20, 1'b0, 1'b0, 3'd0, 8'hDF, 4'd8},  // R8
    '{1'b0, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0, 8'hDE, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd7, 8'hD8, 4'd10}, // R10
    '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd7, 8'hD8, 4'd10}  // R10
  };

  logic             clk;
  logic             rst_n;
  logic             alloc_valid;
  logic [NREG-1:0]  alloc_src, alloc_dst;
  logic [DEPTH-1:0] grant;
  logic             commit, flush;
  logic [2:0]       flush_pos;
  logic [DEPTH-1:0] req;
  int               checks;
  int               errors;

  wkq_wakeup_array #(.DEPTH(DEPTH), .NREG(NREG)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid_i (alloc_valid),
    .alloc_src_i   (alloc_src),
    .alloc_dst_i   (alloc_dst),
    .grant_i       (grant),
    .commit_i      (commit),
    .flush_i       (flush),
    .flush_pos_i   (flush_pos),
    .req_o         (req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic idle();
    alloc_valid = 1'b0;
    alloc_src   = '0;
    alloc_dst   = '0;
    grant       = '0;
    commit      = 1'b0;
    flush       = 1'b0;
    flush_pos   = '0;
  endtask

  task automatic check(input int rid, input logic [7:0] exp, input string what);
    checks++;
    if (req !== exp) begin
      errors++;
      $display("FAIL R%0d %s: req_o actual %h expected %h", rid, what, req, exp);
    end
  endtask

  task automatic step(input vec_t v, input int n);
    alloc_valid = v.alloc;
    alloc_src   = v.src;
    alloc_dst   = v.dst;
    grant       = v.gnt;
    commit      = v.commit;
    flush       = v.flush;
    flush_pos   = v.fpos;
    @(posedge clk);
    @(negedge clk);
    idle();
    check(int'(v.rid), v.exp, $sformatf("vector %0d", n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    checks = 0;
    errors = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 8'h00, "during reset");           // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(TBL[i], i);

    // R1: reset in mid-run clears all rows
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, 8'h00, "asynchronous reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: commit on empty queue ignored; R1: next allocation lands in slot 0
    v = '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00, 4'd9};
    step(v, 100);
    v = '{1'b1, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 8'h01, 4'd1};
    step(v, 101);
    // R5: reader of r1 younger than r0 writer is not blocked
    v = '{1'b1, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h03, 4'd5};
    step(v, 102);
    // R3: reader of r0 blocked by the slot 0 writer
    v = '{1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h03, 4'd3};
    step(v, 103);
    // R4: grant slot 0 and slot 1 together, slot 2 wakes
    v = '{1'b0, 8'h00, 8'h00, 8'h03, 1'b0, 1'b0, 3'd0, 8'h04, 4'd4};
    step(v, 104);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule